// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the status bits a flash device returns on bus reads while its internal controller is programming or erasing. The controller supplies the operation in progress, a busy flag, a suspend flag, the open/closed state of the block-erase address window, the data bit being programmed and whether the current read hits a block under erase. The block answers with five bits: a data-polling bit, a toggle bit, a sticky error bit, an erase-timer bit and a second toggle bit that is confined to blocks under erase.

Each bit follows its own rule. The polling and erase-timer bits are decoded directly from the current inputs. The two toggle bits are flip-flops that invert after qualifying read strobes. The error bit is a latch that is set on a failure pulse and cleared only by a reset command. Operation codes are 2'b00 program, 2'b01 chip erase, 2'b10 block erase and 2'b11 no operation. An operation is active while `busy` or `suspend` is high. `suspend` means an erase is halted; a program started during the suspend is presented with `suspend` low.

Top module: `flash_status_gen`

## Requirements
- R1: Following a synchronous active-low reset with all inputs low, the toggle, alternate-toggle and error outputs read 0.
- R2: While active with op code 2'b00 (program), `dq7_poll` equals the inverse of `prog_bit` in the same cycle.
- R3: While `busy` is high with op code 2'b01 or 2'b10 (erase) and `suspend` low, `dq7_poll` reads 0.
- R4: While `suspend` is high with an erase op code, `dq7_poll` reads 1.
- R5: A cycle with `fail_evt` high makes `dq5_err` read 1 from the next cycle on. It stays 1 until a cycle with `reset_cmd` high and `fail_evt` low, after which it reads 0. If both are high in the same cycle, the error is set.
- R6: `dq6_tog` inverts one cycle after each cycle in which `rd_stb` and `busy` are high and `suspend` is low. Otherwise it holds its value.
- R7: `dq2_alt` inverts one cycle after each `rd_stb` cycle in which an erase op code is active and `addr_in_erase` is high. It holds for reads with `addr_in_erase` low, for reads during a program and when idle.
- R8: `dq3_etimer` reads 0 while a block erase is busy with `erase_window` high. It reads 1 while an erase is busy with `erase_window` low, and 0 for program, when idle and when suspended.
- R9: Op code 2'b11 gives `dq7_poll`, `dq3_etimer` at 0 and never advances `dq2_alt`, even when busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | Operation in progress (00 program, 01 chip erase, 10 block erase, 11 none) |
| busy | input | 1 | Controller is executing the operation |
| suspend | input | 1 | Erase is halted in suspend |
| erase_window | input | 1 | Block-erase address window is still open |
| addr_in_erase | input | 1 | Read address lies in a block under erase |
| prog_bit | input | 1 | Top data bit being programmed |
| rd_stb | input | 1 | One-cycle status read strobe |
| fail_evt | input | 1 | Operation failure pulse |
| reset_cmd | input | 1 | Read/reset command received |
| dq7_poll | output | 1 | Data-polling bit |
| dq6_tog | output | 1 | Toggle bit |
| dq5_err | output | 1 | Sticky error bit |
| dq3_etimer | output | 1 | Erase-timer bit |
| dq2_alt | output | 1 | Alternate toggle bit |

## Verification
The hardest situation to reach is a suspended erase. Here the two toggle bits must part ways: the alternate toggle keeps advancing on reads of the erased block while the main toggle freezes. Driving `suspend` high with `busy` low and alternating `addr_in_erase` across read strobes reaches this state, and the scoreboard predicts both bits from its own model. A failure pulse that coincides with a reset command is also driven explicitly, to show the set-wins ordering of the error bit.

// File: rtl/fsg_pkg.sv
// Shared operation encoding for the flash status generator.
package fsg_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PROG   = 2'b00,
        OP_CERASE = 2'b01,
        OP_BERASE = 2'b10,
        OP_NONE   = 2'b11
    } op_e;

    // True for both erase flavours.
    function automatic logic is_erase(input op_e op);
        return (op == OP_CERASE) || (op == OP_BERASE);
    endfunction
endpackage

// File: rtl/fsg_poll_decode.sv
// Combinational decode of the data-polling and erase-timer bits.
// Assumes inputs are stable for the read cycle; no state is held here.
module fsg_poll_decode
    import fsg_pkg::*;
(
    input  op_e  op,
    input  logic busy,
    input  logic suspend,
    input  logic erase_window,
    input  logic prog_bit,
    output logic poll_bit,
    output logic timer_bit
);
    logic active;
    assign active = busy | suspend;

    // Polling bit: inverted program data, erased-state complement, or suspend marker.
    always_comb begin
        poll_bit = 1'b0;
        if (active) begin
            if (op == OP_PROG)      poll_bit = ~prog_bit;
            else if (is_erase(op))  poll_bit = suspend;
        end
    end

    // Erase timer: set only once a running erase has closed its address window.
    always_comb begin
        timer_bit = 1'b0;
        if (busy && !suspend && is_erase(op))
            timer_bit = ~erase_window;
    end
endmodule

// File: rtl/fsg_toggle_cell.sv
// One toggle flip-flop that inverts after each cycle with adv high.
// Assumes adv is already qualified by the caller.
module fsg_toggle_cell #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic q
);
    // Toggle register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= INIT;
        else if (adv) q <= ~q;
    end

    // R6 R7
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (q != $past(q)));
    // R6 R7
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));
endmodule

// File: rtl/fsg_err_latch.sv
// Sticky error latch: set by a failure pulse, cleared by a reset command.
// Assumes a simultaneous set and clear means a fresh failure, so set wins.
module fsg_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_q
);
    // Error state with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     err_q <= 1'b0;
        else if (set_i) err_q <= 1'b1;
        else if (clr_i) err_q <= 1'b0;
    end

    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> err_q);
    // R5
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && clr_i) |=> !err_q);
    // R5
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(err_q));
endmodule

// File: rtl/flash_status_gen.sv
// Status bit generator for an embedded program/erase controller.
// Polling and erase-timer bits are decoded from live inputs. The two
// toggle bits and the error bit are registered, change one cycle after
// their qualifying event, and use a synchronous active-low reset.
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter bit TOG_INIT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_code,
    input  logic            busy,
    input  logic            suspend,
    input  logic            erase_window,
    input  logic            addr_in_erase,
    input  logic            prog_bit,
    input  logic            rd_stb,
    input  logic            fail_evt,
    input  logic            reset_cmd,
    output logic            dq7_poll,
    output logic            dq6_tog,
    output logic            dq5_err,
    output logic            dq3_etimer,
    output logic            dq2_alt
);
    localparam int NUM_TOG = 2;
    localparam int TOG_MAIN = 0;
    localparam int TOG_ALT  = 1;

    op_e               op;
    logic [NUM_TOG-1:0] tog_adv;
    logic [NUM_TOG-1:0] tog_q;

    assign op = op_e'(op_code);

    // Advance conditions: main toggle while running, alternate on erased-block reads.
    always_comb begin
        tog_adv[TOG_MAIN] = rd_stb & busy & ~suspend;
        tog_adv[TOG_ALT]  = rd_stb & addr_in_erase & is_erase(op) & (busy | suspend);
    end

    fsg_poll_decode u_poll (
        .op           (op),
        .busy         (busy),
        .suspend      (suspend),
        .erase_window (erase_window),
        .prog_bit     (prog_bit),
        .poll_bit     (dq7_poll),
        .timer_bit    (dq3_etimer)
    );

    for (genvar g = 0; g < NUM_TOG; g++) begin : g_tog
        fsg_toggle_cell #(.INIT(TOG_INIT)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (tog_adv[g]),
            .q     (tog_q[g])
        );
    end

    assign dq6_tog = tog_q[TOG_MAIN];
    assign dq2_alt = tog_q[TOG_ALT];

    fsg_err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fail_evt),
        .clr_i (reset_cmd),
        .err_q (dq5_err)
    );

    // R2
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy || suspend) && op_code == 2'b00) |-> (dq7_poll == !prog_bit));
    // R4
    susp_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && (op_code == 2'b01 || op_code == 2'b10)) |-> dq7_poll);
    // R8
    window_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_code == 2'b10 && erase_window) |-> !dq3_etimer);
    // R9
    noop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b11) |=> $stable(dq2_alt));
endmodule

// File: tb/flash_status_gen_tb.sv
// Scoreboard bench: the driver models expected bits and queues them,
// the monitor pops and compares shortly after each rising edge.
module flash_status_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_code = 2'b11;
    logic busy = 0, suspend = 0, erase_window = 0, addr_in_erase = 0;
    logic prog_bit = 0, rd_stb = 0, fail_evt = 0, reset_cmd = 0;
    logic dq7_poll, dq6_tog, dq5_err, dq3_etimer, dq2_alt;

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int n_vec = 0;
    int n_bad = 0;
    logic m_t6 = 0, m_t2 = 0, m_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_status_gen dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .busy(busy),
        .suspend(suspend), .erase_window(erase_window),
        .addr_in_erase(addr_in_erase), .prog_bit(prog_bit), .rd_stb(rd_stb),
        .fail_evt(fail_evt), .reset_cmd(reset_cmd), .dq7_poll(dq7_poll),
        .dq6_tog(dq6_tog), .dq5_err(dq5_err), .dq3_etimer(dq3_etimer),
        .dq2_alt(dq2_alt)
    );

    // Driver: apply one vector at a falling edge and queue the expected bits.
    task automatic apply(input logic [1:0] op, input logic b, input logic s,
                         input logic w, input logic a, input logic p,
                         input logic rd, input logic f, input logic rc,
                         input string req);
        logic er, act, e7, e3;
        item_t it;
        @(negedge clk);
        op_code = op; busy = b; suspend = s; erase_window = w;
        addr_in_erase = a; prog_bit = p; rd_stb = rd; fail_evt = f; reset_cmd = rc;
        er  = (op == 2'b01) || (op == 2'b10);
        act = b || s;
        if (f) m_err = 1'b1; else if (rc) m_err = 1'b0;
        if (rd && b && !s) m_t6 = ~m_t6;
        if (rd && a && er && act) m_t2 = ~m_t2;
        e7 = 1'b0;
        if (act && op == 2'b00) e7 = ~p;
        else if (act && er) e7 = s;
        e3 = (b && !s && er) ? ~w : 1'b0;
        it.exp = {e7, m_t6, m_err, e3, m_t2};
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after each rising edge once registers have settled.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            logic [4:0] act_v;
            it = sb_q.pop_front();
            act_v = {dq7_poll, dq6_tog, dq5_err, dq3_etimer, dq2_alt};
            n_vec++;
            if (act_v !== it.exp) begin
                n_bad++;
                $display("FAIL %s: dq7,6,5,3,2 actual %b expected %b", it.req, act_v, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset with activity on the inputs.
        rd_stb = 1; busy = 1; fail_evt = 1;
        repeat (3) @(negedge clk);
        rd_stb = 0; busy = 0; fail_evt = 0;
        @(negedge clk);
        rst_n = 1;
        //            op    b s w a p rd f rc
        apply(2'b11, 0,0,0,0,0, 0,0,0, "R1");
        // R2 program polling
        apply(2'b00, 1,0,0,0,0, 0,0,0, "R2");
        apply(2'b00, 1,0,0,0,1, 0,0,0, "R2");
        // R6 toggle during program; R7 alt holds on program reads
        apply(2'b00, 1,0,0,1,1, 1,0,0, "R6");
        apply(2'b00, 1,0,0,1,1, 1,0,0, "R6");
        apply(2'b00, 1,0,0,0,0, 1,0,0, "R6");
        apply(2'b00, 1,0,0,1,0, 1,0,0, "R7");
        // R6 idle reads hold
        apply(2'b00, 0,0,0,0,0, 1,0,0, "R6");
        apply(2'b00, 0,0,0,0,0, 1,0,0, "R6");
        // R3 chip erase, R8 timer
        apply(2'b01, 1,0,0,0,1, 0,0,0, "R3");
        apply(2'b01, 1,0,0,1,0, 1,0,0, "R7");
        // R8 block erase window open then closed
        apply(2'b10, 1,0,1,0,0, 0,0,0, "R8");
        apply(2'b10, 1,0,1,1,0, 1,0,0, "R8");
        apply(2'b10, 1,0,0,0,0, 0,0,0, "R8");
        // R7 reads of other blocks hold the alternate toggle
        apply(2'b10, 1,0,0,0,0, 1,0,0, "R7");
        apply(2'b10, 1,0,0,1,0, 1,0,0, "R7");
        // R4 suspended erase: poll 1, alt toggles, main toggle frozen
        apply(2'b10, 0,1,0,0,0, 0,0,0, "R4");
        apply(2'b10, 0,1,0,1,0, 1,0,0, "R4");
        apply(2'b10, 0,1,0,0,0, 1,0,0, "R7");
        apply(2'b10, 0,1,0,1,0, 1,0,0, "R6");
        apply(2'b01, 0,1,0,1,1, 1,0,0, "R4");
        // R8 timer zero when idle and for program
        apply(2'b10, 0,0,0,0,0, 0,0,0, "R8");
        apply(2'b00, 1,0,0,0,0, 0,0,0, "R8");
        // R5 sticky error
        apply(2'b01, 1,0,0,0,0, 0,1,0, "R5");
        apply(2'b01, 1,0,0,0,0, 0,0,0, "R5");
        apply(2'b01, 1,0,0,0,0, 1,0,0, "R5");
        apply(2'b01, 0,0,0,0,0, 0,0,1, "R5");
        apply(2'b01, 0,0,0,0,0, 0,0,0, "R5");
        apply(2'b10, 1,0,0,0,0, 0,1,1, "R5");
        apply(2'b10, 1,0,0,0,0, 0,0,0, "R5");
        apply(2'b10, 0,0,0,0,0, 0,0,1, "R5");
        // R9 op code 11 is quiet even when busy
        apply(2'b11, 1,0,0,1,0, 1,0,0, "R9");
        apply(2'b11, 1,0,0,1,1, 1,0,0, "R9");
        apply(2'b11, 0,1,0,1,0, 1,0,0, "R9");
        // Drain the scoreboard.
        apply(2'b11, 0,0,0,0,0, 0,0,0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule